// File: doc/BRIEF.md
# Handshaked Monitor Channel Transceiver

This block moves message bytes across a one-byte monitor slot that recurs once per frame on a framed serial bus. Two handshake bits travel with the slot. MX is the sender's "byte valid" bit and MR is the receiver's "byte taken" bit. Both are active low. The block holds a transmitter and a receiver that work independently, so one instance can talk to a remote end. Its transmitter can also be looped back to its own receiver.

The host writes a byte and enables the transmitter. The transmitter puts the byte in the slot with MX active. It keeps the byte there, frame after frame, until it sees MR fall, and then raises a one-cycle data-acknowledge pulse. The host then writes the next byte, or clears the continue control to finish the message.

The receiver takes a byte only when the same value has arrived in two consecutive frames with MX active (a double last-look). It then drives MR active and hands the byte to the host. MX inactive for one frame separates bytes. MX inactive for two frames after an acknowledged byte ends the message. Either end can abort a byte exchange by holding its own handshake bit inactive for two frames.

Top module: `mon_xcvr`

## Requirements
- R1: After reset, slot_mx_out and slot_mr_out are 1 (inactive), tx_active is 0, and the pulses tx_ack_irq, tx_aborted, rx_valid, rx_eom and rx_aborted are 0.
- R2: The transmitter starts a message only when tx_enable is 1 and a byte has been written. It then places that byte on slot_dout and drives slot_mx_out to 0 at the next frame tick. With tx_enable at 0, a written byte is not sent and slot_mx_out stays 1.
- R3: While a byte is in flight, slot_dout and slot_mx_out stay unchanged at every frame until a falling edge of slot_mr_in is sampled. Each byte of a message forms exactly one run of frames with MX at 0.
- R4: When the transmitter samples slot_mr_in at 0 after a 1, it gives a single-cycle tx_ack_irq. It then keeps the byte and MX at 0 until the host writes the next byte or clears tx_continue.
- R5: The receiver accepts a byte only when two consecutive frames both carry MX at 0 and the same byte value. A frame with MX at 1 between them restarts the comparison. On acceptance it drives slot_mr_out to 0 and gives a single-cycle rx_valid, with the byte on rx_rdata.
- R6: Between two bytes of one message, slot_mx_out is 1 for exactly one frame. The receiver releases MR (drives it to 1) on that frame and does not report end of message.
- R7: If tx_continue is 0 when an acknowledged byte is held, MX goes to 1 and stays there. A receiver that sees MX at 1 for two consecutive frames after an acknowledged byte gives a single-cycle rx_eom.
- R8: A tx_abort request made while a byte awaits acknowledge drives MX to 1 for at least two frames and ends in a tx_aborted pulse. A receiver that is partway through a byte and sees MX at 1 for two consecutive frames gives rx_aborted and no rx_valid. Requests made while the transmitter is idle are discarded.
- R9: An rx_abort_req takes effect while the receiver holds an acknowledge. MR goes to 1 and stays there until MX goes to 1, at which point rx_aborted pulses. A transmitter holding an acknowledged byte that samples MR at 1 in two consecutive frames gives tx_aborted and returns to idle with MX at 1.
- R10: slot_dout, slot_mx_out and slot_mr_out change only on the clock edge at which frame_tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle pulse per frame; the slot is sampled and updated on it |
| tx_enable | input | 1 | Allows the transmitter to start a message |
| tx_continue | input | 1 | Keep the message open; clearing it ends the message after the held byte |
| tx_wdata | input | DATA_W | Next byte to send |
| tx_write | input | 1 | Loads tx_wdata as the next byte |
| tx_abort | input | 1 | Request to abort the byte awaiting acknowledge |
| tx_ack_irq | output | 1 | Pulse: far end acknowledged the current byte |
| tx_aborted | output | 1 | Pulse: the transmission was aborted by either end |
| tx_active | output | 1 | Transmitter is inside a message |
| rx_abort_req | input | 1 | Request the receiver to abort the exchange |
| rx_rdata | output | DATA_W | Last accepted byte |
| rx_valid | output | 1 | Pulse: a byte was accepted |
| rx_eom | output | 1 | Pulse: end of message seen |
| rx_aborted | output | 1 | Pulse: receive exchange aborted |
| slot_dout | output | DATA_W | Byte driven into the monitor slot |
| slot_mx_out | output | 1 | Outgoing MX bit, active low |
| slot_mr_out | output | 1 | Outgoing MR bit, active low |
| slot_din | input | DATA_W | Byte sampled from the monitor slot |
| slot_mx_in | input | 1 | Incoming MX bit, active low |
| slot_mr_in | input | 1 | Incoming MR bit, active low |

## Verification
The bench sweeps messages of one to six bytes in three data patterns through a loopback. One pattern repeats the same value every byte. A receiver that judged new bytes by a change of value would merge those repeats, and a transmitter that dropped the one-frame gap would make them unseparable. A scripted far end sends a changing byte, and also a byte interrupted by one inactive MX frame. A receiver lacking a true consecutive-frame last-look would accept too early, or across the gap. Aborts are driven from both ends and while idle. A design that treated a two-frame inactive handshake as end of message would report rx_eom instead of an abort, and one that kept a stale abort request would kill the next message.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_SEND, TX_HOLD, TX_GAP, TX_ABORT
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_LOOK, RX_ACK, RX_GAP, RX_WAIT_END
  } rx_state_e;
endpackage

// File: rtl/mon_tx.sv
module mon_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable,
  input  logic              cont,
  input  logic [DATA_W-1:0] wdata,
  input  logic              write,
  input  logic              abort_req,
  input  logic              mr_in,
  output logic [DATA_W-1:0] dout,
  output logic              mx_out,
  output logic              ack_irq,
  output logic              aborted,
  output logic              active
);
  import mon_pkg::*;

  tx_state_e         st;
  logic [DATA_W-1:0] hold_q;
  logic              pend;
  logic              abt_q;
  logic              mr_prev;
  logic              mr_hi;

  assign active = (st != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TX_IDLE;
      hold_q  <= '0;
      pend    <= 1'b0;
      abt_q   <= 1'b0;
      dout    <= '0;
      mx_out  <= 1'b1;
      mr_prev <= 1'b1;
      mr_hi   <= 1'b0;
      ack_irq <= 1'b0;
      aborted <= 1'b0;
    end else begin
      ack_irq <= 1'b0;
      aborted <= 1'b0;
      if (write) begin
        hold_q <= wdata;
        pend   <= 1'b1;
      end
      if (abort_req) abt_q <= 1'b1;
      if (tick) begin
        mr_prev <= mr_in;
        case (st)
          TX_IDLE: begin
            abt_q <= 1'b0;
            mr_hi <= 1'b0;
            if (enable && pend) begin
              dout   <= hold_q;
              pend   <= write;
              mx_out <= 1'b0;
              st     <= TX_SEND;
            end
          end
          TX_SEND: begin
            if (abt_q) begin
              abt_q  <= 1'b0;
              mx_out <= 1'b1;
              st     <= TX_ABORT;
            end else if (!mr_in && mr_prev) begin
              ack_irq <= 1'b1;
              mr_hi   <= 1'b0;
              st      <= TX_HOLD;
            end
          end
          TX_HOLD: begin
            abt_q <= 1'b0;
            if (mr_in) begin
              if (mr_hi) begin
                aborted <= 1'b1;
                mx_out  <= 1'b1;
                st      <= TX_IDLE;
              end else begin
                mr_hi <= 1'b1;
              end
            end else begin
              mr_hi <= 1'b0;
              if (!cont) begin
                mx_out <= 1'b1;
                st     <= TX_IDLE;
              end else if (pend) begin
                mx_out <= 1'b1;
                st     <= TX_GAP;
              end
            end
          end
          TX_GAP: begin
            dout   <= hold_q;
            pend   <= write;
            mx_out <= 1'b0;
            st     <= TX_SEND;
          end
          TX_ABORT: begin
            aborted <= 1'b1;
            st      <= TX_IDLE;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mon_rx.sv
module mon_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] din,
  input  logic              mx_in,
  input  logic              abort_req,
  output logic              mr_out,
  output logic [DATA_W-1:0] rdata,
  output logic              valid,
  output logic              eom,
  output logic              aborted
);
  import mon_pkg::*;

  rx_state_e         st;
  logic [DATA_W-1:0] cand;
  logic              hi;
  logic              abt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      cand    <= '0;
      hi      <= 1'b0;
      abt_q   <= 1'b0;
      mr_out  <= 1'b1;
      rdata   <= '0;
      valid   <= 1'b0;
      eom     <= 1'b0;
      aborted <= 1'b0;
    end else begin
      valid   <= 1'b0;
      eom     <= 1'b0;
      aborted <= 1'b0;
      if (abort_req) abt_q <= 1'b1;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            abt_q <= 1'b0;
            if (!mx_in) begin
              cand <= din;
              hi   <= 1'b0;
              st   <= RX_LOOK;
            end
          end
          RX_LOOK: begin
            if (mx_in) begin
              if (hi) begin
                aborted <= 1'b1;
                st      <= RX_IDLE;
              end else begin
                hi <= 1'b1;
              end
            end else if (hi) begin
              cand <= din;
              hi   <= 1'b0;
            end else if (din == cand) begin
              mr_out <= 1'b0;
              rdata  <= din;
              valid  <= 1'b1;
              st     <= RX_ACK;
            end else begin
              cand <= din;
            end
          end
          RX_ACK: begin
            if (abt_q) begin
              abt_q  <= 1'b0;
              mr_out <= 1'b1;
              st     <= RX_WAIT_END;
            end else if (mx_in) begin
              mr_out <= 1'b1;
              st     <= RX_GAP;
            end
          end
          RX_GAP: begin
            if (mx_in) begin
              eom <= 1'b1;
              st  <= RX_IDLE;
            end else begin
              cand <= din;
              hi   <= 1'b0;
              st   <= RX_LOOK;
            end
          end
          RX_WAIT_END: begin
            if (mx_in) begin
              aborted <= 1'b1;
              st      <= RX_IDLE;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mon_xcvr.sv
module mon_xcvr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_tick,
  input  logic              tx_enable,
  input  logic              tx_continue,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_write,
  input  logic              tx_abort,
  output logic              tx_ack_irq,
  output logic              tx_aborted,
  output logic              tx_active,
  input  logic              rx_abort_req,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_valid,
  output logic              rx_eom,
  output logic              rx_aborted,
  output logic [DATA_W-1:0] slot_dout,
  output logic              slot_mx_out,
  output logic              slot_mr_out,
  input  logic [DATA_W-1:0] slot_din,
  input  logic              slot_mx_in,
  input  logic              slot_mr_in
);
  mon_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .tick      (frame_tick),
    .enable    (tx_enable),
    .cont      (tx_continue),
    .wdata     (tx_wdata),
    .write     (tx_write),
    .abort_req (tx_abort),
    .mr_in     (slot_mr_in),
    .dout      (slot_dout),
    .mx_out    (slot_mx_out),
    .ack_irq   (tx_ack_irq),
    .aborted   (tx_aborted),
    .active    (tx_active)
  );

  mon_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .tick      (frame_tick),
    .din       (slot_din),
    .mx_in     (slot_mx_in),
    .abort_req (rx_abort_req),
    .mr_out    (slot_mr_out),
    .rdata     (rx_rdata),
    .valid     (rx_valid),
    .eom       (rx_eom),
    .aborted   (rx_aborted)
  );
endmodule

// File: rtl/mon_xcvr_chk.sv
module mon_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_tick,
  input logic              tx_ack_irq,
  input logic              tx_aborted,
  input logic [DATA_W-1:0] rx_rdata,
  input logic              rx_valid,
  input logic              rx_eom,
  input logic              rx_aborted,
  input logic [DATA_W-1:0] slot_dout,
  input logic              slot_mx_out,
  input logic              slot_mr_out,
  input logic [DATA_W-1:0] slot_din,
  input logic              slot_mx_in,
  input logic              slot_mr_in
);
  p_quiet_between_ticks_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_tick) |-> ($stable(slot_dout) && $stable(slot_mx_out) && $stable(slot_mr_out)));

  p_byte_held_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !slot_mx_out) |=> $stable(slot_dout));

  p_ack_on_mr_low_r4: assert property (@(posedge clk) disable iff (rst)
    tx_ack_irq |-> ($past(frame_tick) && !$past(slot_mr_in)));

  p_accept_needs_mx_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!slot_mr_out && $past(frame_tick) && !$past(slot_mx_in) && ($past(slot_din) == rx_rdata)));

  p_rx_pulses_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid, rx_eom, rx_aborted}));

  p_eom_after_mx_idle_r7: assert property (@(posedge clk) disable iff (rst)
    rx_eom |-> ($past(slot_mx_in) && slot_mr_out));

  p_tx_abort_mx_idle_r8: assert property (@(posedge clk) disable iff (rst)
    tx_aborted |-> slot_mx_out);

  p_rx_abort_mr_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rx_aborted |-> slot_mr_out);
endmodule

bind mon_xcvr mon_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_tick  (frame_tick),
  .tx_ack_irq  (tx_ack_irq),
  .tx_aborted  (tx_aborted),
  .rx_rdata    (rx_rdata),
  .rx_valid    (rx_valid),
  .rx_eom      (rx_eom),
  .rx_aborted  (rx_aborted),
  .slot_dout   (slot_dout),
  .slot_mx_out (slot_mx_out),
  .slot_mr_out (slot_mr_out),
  .slot_din    (slot_din),
  .slot_mx_in  (slot_mx_in),
  .slot_mr_in  (slot_mr_in)
);

// File: tb/sim_mon_xcvr.sv
module sim_mon_xcvr;
  localparam int W     = 8;
  localparam int TICKP = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic frame_tick;
  int   tcnt;

  logic         tx_enable, tx_continue, tx_write, tx_abort, rx_abort_req;
  logic [W-1:0] tx_wdata;
  logic         tx_ack_irq, tx_aborted, tx_active;
  logic [W-1:0] rx_rdata;
  logic         rx_valid, rx_eom, rx_aborted;
  logic [W-1:0] slot_dout, slot_din;
  logic         slot_mx_out, slot_mr_out, slot_mx_in, slot_mr_in;

  logic         lb;
  logic [W-1:0] s_din;
  logic         s_mx, s_mr;

  always_comb begin
    slot_din   = lb ? slot_dout   : s_din;
    slot_mx_in = lb ? slot_mx_out : s_mx;
    slot_mr_in = lb ? slot_mr_out : s_mr;
  end

  always @(posedge clk) begin
    if (rst) begin
      tcnt       <= 0;
      frame_tick <= 1'b0;
    end else begin
      tcnt       <= (tcnt == TICKP - 1) ? 0 : tcnt + 1;
      frame_tick <= (tcnt == TICKP - 1);
    end
  end

  mon_xcvr #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .frame_tick(frame_tick),
    .tx_enable(tx_enable), .tx_continue(tx_continue), .tx_wdata(tx_wdata),
    .tx_write(tx_write), .tx_abort(tx_abort),
    .tx_ack_irq(tx_ack_irq), .tx_aborted(tx_aborted), .tx_active(tx_active),
    .rx_abort_req(rx_abort_req), .rx_rdata(rx_rdata), .rx_valid(rx_valid),
    .rx_eom(rx_eom), .rx_aborted(rx_aborted),
    .slot_dout(slot_dout), .slot_mx_out(slot_mx_out), .slot_mr_out(slot_mr_out),
    .slot_din(slot_din), .slot_mx_in(slot_mx_in), .slot_mr_in(slot_mr_in)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: counts pulses, records bytes, traces MX per frame
  logic [W-1:0] got [0:255];
  int got_n = 0, eom_n = 0, rab_n = 0, tab_n = 0, ack_n = 0;
  int seg_n = 0, hi_run = 0, bad_gap = 0, r10_bad = 0;
  bit prev_mx = 1'b1;
  bit prev_tk = 1'b1;
  logic [W+1:0] prev_out;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        got[got_n[7:0]] = rx_rdata;
        got_n++;
      end
      if (rx_eom)     eom_n++;
      if (rx_aborted) rab_n++;
      if (tx_aborted) tab_n++;
      if (tx_ack_irq) ack_n++;
      if (frame_tick) begin
        if (!slot_mx_out) begin
          if (prev_mx) begin
            seg_n++;
            if (seg_n > 1 && hi_run != 1) bad_gap++;
          end
          hi_run = 0;
        end else begin
          hi_run++;
        end
        prev_mx = slot_mx_out;
      end
      if (!prev_tk && (prev_out != {slot_dout, slot_mx_out, slot_mr_out})) r10_bad++;
      prev_tk  = frame_tick;
      prev_out = {slot_dout, slot_mx_out, slot_mr_out};
    end
  end

  function automatic logic [W-1:0] pat_byte(input int len, input int pat, input int i);
    if (pat == 2) return 8'hA5;
    return W'((len * 29 + i * 67 + pat * 113 + 5) ^ (pat * 255));
  endfunction

  task automatic wait_cnt(input int sel, input int target);
    int guard = 0;
    int v;
    forever begin
      @(posedge clk);
      case (sel)
        0: v = ack_n;
        1: v = eom_n;
        2: v = rab_n;
        default: v = tab_n;
      endcase
      if (v >= target || guard > 3000) break;
      guard++;
    end
  endtask

  task automatic next_frame();
    do @(negedge clk); while (!frame_tick);
    @(negedge clk);
    #2;
  endtask

  task automatic write_byte(input logic [W-1:0] b);
    @(negedge clk);
    tx_wdata = b;
    tx_write = 1'b1;
    @(negedge clk);
    tx_write = 1'b0;
  endtask

  task automatic send_msg(input int len, input int pat);
    int g0, e0, a0, bad;
    g0 = got_n; e0 = eom_n; a0 = ack_n;
    @(negedge clk);
    seg_n = 0; bad_gap = 0; hi_run = 0;
    tx_continue = 1'b1;
    write_byte(pat_byte(len, pat, 0));
    for (int i = 1; i < len; i++) begin
      wait_cnt(0, a0 + i);
      write_byte(pat_byte(len, pat, i));
    end
    wait_cnt(0, a0 + len);
    @(negedge clk);
    tx_continue = 1'b0;
    wait_cnt(1, e0 + 1);
    @(negedge clk);
    chk(got_n - g0 == len, "R5 bytes accepted", got_n - g0, len);
    bad = 0;
    for (int i = 0; i < len; i++)
      if (got[(g0 + i) & 255] != pat_byte(len, pat, i)) bad++;
    chk(bad == 0, "R5 byte values", bad, 0);
    chk(eom_n == e0 + 1, "R7 end of message", eom_n - e0, 1);
    chk(seg_n == len, "R3 one MX run per byte", seg_n, len);
    chk(bad_gap == 0, "R6 single-frame gap", bad_gap, 0);
    chk(slot_mx_out && !tx_active, "R7 MX idle after message", {slot_mx_out, tx_active}, 2);
    chk(ack_n == a0 + len, "R4 one ack per byte", ack_n - a0, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g0, e0, r0, t0, a0;
    rst = 1'b1;
    tx_enable = 1'b0; tx_continue = 1'b0; tx_write = 1'b0; tx_abort = 1'b0;
    rx_abort_req = 1'b0; tx_wdata = '0;
    lb = 1'b1; s_din = '0; s_mx = 1'b1; s_mr = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(slot_mx_out && slot_mr_out, "R1 handshake bits idle", {slot_mx_out, slot_mr_out}, 3);
    chk(!tx_active, "R1 transmitter idle", tx_active, 0);
    chk({tx_ack_irq, tx_aborted, rx_valid, rx_eom, rx_aborted} == 5'b0, "R1 no pulses",
        {tx_ack_irq, tx_aborted, rx_valid, rx_eom, rx_aborted}, 0);

    // R2 no start without enable
    g0 = got_n; e0 = eom_n;
    write_byte(8'h3C);
    repeat (6) next_frame();
    chk(slot_mx_out && !tx_active, "R2 disabled holds MX idle", {slot_mx_out, tx_active}, 2);
    chk(got_n == g0, "R2 nothing received while disabled", got_n - g0, 0);
    @(negedge clk);
    tx_enable = 1'b1;
    next_frame();
    next_frame();
    chk(!slot_mx_out && slot_dout == 8'h3C, "R2 byte in slot after enable", slot_dout, 8'h3C);
    wait_cnt(1, e0 + 1);
    @(negedge clk);
    chk(got_n == g0 + 1 && got[g0 & 255] == 8'h3C, "R2 byte delivered", got[g0 & 255], 8'h3C);

    // sweep of lengths and patterns over loopback
    for (int len = 1; len <= 6; len++)
      for (int pat = 0; pat < 3; pat++)
        send_msg(len, pat);

    // R5 scripted far end: changing byte, then an interrupted byte
    lb = 1'b0;
    next_frame();
    g0 = got_n; e0 = eom_n;
    s_mx = 1'b0; s_din = 8'h11;
    next_frame();
    s_din = 8'h22;
    next_frame();
    chk(got_n == g0 && slot_mr_out, "R5 no accept on differing looks", got_n - g0, 0);
    next_frame();
    chk(got_n == g0 + 1 && got[g0 & 255] == 8'h22, "R5 accept after two equal looks", got_n - g0, 1);
    chk(!slot_mr_out, "R5 MR driven active", slot_mr_out, 0);
    s_mx = 1'b1;
    next_frame();
    chk(slot_mr_out && eom_n == e0, "R6 one idle frame releases MR only", eom_n - e0, 0);
    s_mx = 1'b0; s_din = 8'h33;
    next_frame();
    s_mx = 1'b1;
    next_frame();
    s_mx = 1'b0;
    next_frame();
    chk(got_n == g0 + 1, "R5 idle frame restarts last-look", got_n - g0, 1);
    next_frame();
    chk(got_n == g0 + 2 && got[(g0 + 1) & 255] == 8'h33, "R5 accept after restart", got_n - g0, 2);
    s_mx = 1'b1;
    next_frame();
    next_frame();
    chk(eom_n == e0 + 1, "R7 two idle frames end message", eom_n - e0, 1);
    lb = 1'b1;
    next_frame();
    next_frame();

    // R8 transmitter abort before acknowledge
    g0 = got_n; e0 = eom_n; r0 = rab_n; t0 = tab_n;
    tx_continue = 1'b1;
    write_byte(8'h99);
    do @(negedge clk); while (!tx_active);
    tx_abort = 1'b1;
    @(negedge clk);
    tx_abort = 1'b0;
    wait_cnt(3, t0 + 1);
    wait_cnt(2, r0 + 1);
    @(negedge clk);
    chk(tab_n == t0 + 1, "R8 tx_aborted pulse", tab_n - t0, 1);
    chk(rab_n == r0 + 1, "R8 receiver sees abort", rab_n - r0, 1);
    chk(got_n == g0 && eom_n == e0, "R8 no byte and no end", got_n - g0, 0);
    chk(slot_mx_out && !tx_active, "R8 transmitter idle", {slot_mx_out, tx_active}, 2);

    // R8 abort while idle is discarded
    tx_continue = 1'b0;
    t0 = tab_n;
    @(negedge clk);
    tx_abort = 1'b1;
    @(negedge clk);
    tx_abort = 1'b0;
    repeat (3) next_frame();
    send_msg(2, 0);
    chk(tab_n == t0, "R8 idle abort ignored", tab_n - t0, 0);

    // R9 receiver abort while holding acknowledge
    g0 = got_n; e0 = eom_n; r0 = rab_n; t0 = tab_n; a0 = ack_n;
    tx_continue = 1'b1;
    write_byte(8'h77);
    wait_cnt(0, a0 + 1);
    @(negedge clk);
    rx_abort_req = 1'b1;
    @(negedge clk);
    rx_abort_req = 1'b0;
    wait_cnt(3, t0 + 1);
    wait_cnt(2, r0 + 1);
    @(negedge clk);
    chk(tab_n == t0 + 1, "R9 transmitter sees abort", tab_n - t0, 1);
    chk(rab_n == r0 + 1, "R9 rx_aborted pulse", rab_n - r0, 1);
    chk(slot_mx_out && slot_mr_out && !tx_active, "R9 both ends idle",
        {slot_mx_out, slot_mr_out, tx_active}, 6);
    chk(eom_n == e0 && got_n == g0 + 1, "R9 byte kept no end", eom_n - e0, 0);
    tx_continue = 1'b0;
    repeat (2) next_frame();

    chk(r10_bad == 0, "R10 outputs move only on tick", r10_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule